// File: doc/BRIEF.md
# Write-Masked PHY Control Register Bank

This block is a small bank of 32-bit registers on a simple valid/ready register bus. It holds seven control words and one read-only status word. The decoded control fields drive a PHY power sequencer directly: power enable, delay-line enable, drive-strength code, delay-line frequency band and output tap delay.

Every write is a self-masking update. The low halfword carries the new payload. The high halfword is a per-bit enable for that payload, so software can change one field without reading the register first.

The status word reports two completion flags from the PHY: calibration finished and delay line locked. Both flags pass through a two-flop synchronizer before a read can see them. The bus accepts one access every cycle. Read data comes back one cycle after the access is accepted.

Top module: `phyctl_regbank`

## Requirements
- R1: On an accepted write to a control word, low bit x (0..15) takes wdata bit x only when wdata bit x+16 is 1; otherwise it keeps its previous value.
- R2: Seven control words sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. A read returns the stored 16 bits in rdata[15:0]. rdata[31:16] is always zero.
- R3: The bank ignores writes to offset 0x20, to 0x1C, to any offset above 0x20 and to any offset that is not a multiple of four. Reads of those unmapped offsets return zero.
- R4: Synchronous reset clears all control words to zero. After reset phy_pwr_on and phy_dll_en are 0 and every field output is 0.
- R5: Word 0x18 drives three outputs. Bit 0 is phy_pwr_on (1 = powered) and bit 1 is phy_dll_en. Bits 6:4 are phy_drive_sel, whose codes are 0=50 Ω, 1=33 Ω, 2=66 Ω, 3=100 Ω and 4=40 Ω.
- R6: Word 0x00 drives three outputs. Bits 13:12 are phy_dll_freq, whose codes are 0=200 MHz, 1=50 MHz, 2=100 MHz and 3=150 MHz. Bit 11 is phy_otap_en and bits 10:7 are phy_otap_sel.
- R7: The status word at 0x20 has cal_done_in in bit 6 and dll_lock_in in bit 5. All its other bits read 0. A flag that changes before clock edge k is seen by reads accepted at edge k+2 or later, and not by reads accepted at edges k or k+1.
- R8: req_ready is 1 outside reset, so one access is accepted per cycle. rsp_valid is 1 in exactly the cycle after an accepted read and is 0 after a write.
- R9: The field outputs show a write in the cycle right after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Bank can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write enable mask [31:16] and payload [15:0] |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| cal_done_in | input | 1 | Asynchronous calibration-finished flag |
| dll_lock_in | input | 1 | Asynchronous delay-line lock flag |
| phy_pwr_on | output | 1 | PHY analog power enable |
| phy_dll_en | output | 1 | Delay-line enable |
| phy_drive_sel | output | 3 | Drive-strength code |
| phy_dll_freq | output | 2 | Delay-line frequency band code |
| phy_otap_en | output | 1 | Output tap delay enable |
| phy_otap_sel | output | 4 | Output tap delay select |

## Verification
Directed writes use masks that cover one bit, a whole field, or no bit at all, while the payload disagrees with the stored value. Each of these outcomes shows a different fault: the mask being ignored, the mask being applied to the wrong half, or the mask being inverted.

Writes go to the status offset, to the gap at 0x1C and to unaligned offsets, each with an all-ones pattern. This separates a correct decode from aliasing onto a control word.

A flag change is followed by three back-to-back status reads, which pins down the synchronizer depth exactly. Random mixes of reads and writes then compare every readback and every field output against a reference model of the masked merge.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

    localparam int DATA_W      = 32;
    localparam int HALF_W      = 16;
    localparam int NUM_CTRL    = 7;
    localparam int CTRL_IDX_W  = $clog2(NUM_CTRL);
    localparam int STATUS_WORD = 8;
    localparam int PWR_IDX     = 6;
    localparam int BAND_IDX    = 0;

    localparam int BIT_PWR      = 0;
    localparam int BIT_DLL_EN   = 1;
    localparam int LSB_DRIVE    = 4;
    localparam int LSB_OTAP_SEL = 7;
    localparam int BIT_OTAP_EN  = 11;
    localparam int LSB_FREQ     = 12;
    localparam int BIT_CAL      = 6;
    localparam int BIT_LOCK     = 5;

    typedef enum logic [2:0] {
        DRV_50  = 3'd0,
        DRV_33  = 3'd1,
        DRV_66  = 3'd2,
        DRV_100 = 3'd3,
        DRV_40  = 3'd4
    } drive_code_e;

    typedef enum logic [1:0] {
        BAND_200 = 2'd0,
        BAND_50  = 2'd1,
        BAND_100 = 2'd2,
        BAND_150 = 2'd3
    } band_code_e;

    typedef struct packed {
        logic                  hit_ctrl;
        logic                  hit_status;
        logic [CTRL_IDX_W-1:0] idx;
    } addr_dec_t;

    typedef struct packed {
        logic       pwr_on;
        logic       dll_en;
        logic [2:0] drive;
        logic [1:0] band;
        logic       otap_en;
        logic [3:0] otap_sel;
    } phy_ctrl_t;

    function automatic logic [HALF_W-1:0] masked_merge(
        input logic [HALF_W-1:0] cur,
        input logic [DATA_W-1:0] wr
    );
        logic [HALF_W-1:0] en;
        en = wr[DATA_W-1:HALF_W];
        return (cur & ~en) | (wr[HALF_W-1:0] & en);
    endfunction

    function automatic phy_ctrl_t extract_fields(
        input logic [HALF_W-1:0] band_word,
        input logic [HALF_W-1:0] pwr_word
    );
        phy_ctrl_t f;
        f.pwr_on   = pwr_word[BIT_PWR];
        f.dll_en   = pwr_word[BIT_DLL_EN];
        f.drive    = pwr_word[LSB_DRIVE +: 3];
        f.band     = band_word[LSB_FREQ +: 2];
        f.otap_en  = band_word[BIT_OTAP_EN];
        f.otap_sel = band_word[LSB_OTAP_SEL +: 4];
        return f;
    endfunction

endpackage

// File: rtl/phyctl_addr_dec.sv
module phyctl_addr_dec
    import phyctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_dec_t         dec
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;

    always_comb begin
        word           = addr[ADDR_W-1:2];
        aligned        = (addr[1:0] == 2'b00);
        dec.hit_ctrl   = aligned && (word < WORD_W'(NUM_CTRL));
        dec.hit_status = aligned && (word == WORD_W'(STATUS_WORD));
        dec.idx        = word[CTRL_IDX_W-1:0];
    end
endmodule

// File: rtl/phyctl_ctrl_regs.sv
module phyctl_ctrl_regs
    import phyctl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [CTRL_IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_CTRL-1:0][HALF_W-1:0] regs
);
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == CTRL_IDX_W'(g))) begin
                regs[g] <= masked_merge(regs[g], wr_data);
            end
        end
    end
endmodule

// File: rtl/phyctl_flag_sync.sv
module phyctl_flag_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/phyctl_regbank.sv
module phyctl_regbank
    import phyctl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              cal_done_in,
    input  logic              dll_lock_in,
    output logic              phy_pwr_on,
    output logic              phy_dll_en,
    output logic [2:0]        phy_drive_sel,
    output logic [1:0]        phy_dll_freq,
    output logic              phy_otap_en,
    output logic [3:0]        phy_otap_sel
);
    addr_dec_t                      dec;
    logic [NUM_CTRL-1:0][HALF_W-1:0] regs;
    logic [1:0]                     flags_sync;
    logic                           acc;
    logic                           wr_acc;
    logic                           rd_acc;
    logic [DATA_W-1:0]              rd_word;
    logic [DATA_W-1:0]              status_word;
    phy_ctrl_t                      fields;

    assign req_ready = 1'b1;
    assign acc       = req_valid && req_ready;
    assign wr_acc    = acc && req_write && dec.hit_ctrl;
    assign rd_acc    = acc && !req_write;

    phyctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    phyctl_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_acc),
        .wr_idx  (dec.idx),
        .wr_data (req_wdata),
        .regs    (regs)
    );

    phyctl_flag_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cal_done_in, dll_lock_in}),
        .dout (flags_sync)
    );

    always_comb begin
        status_word           = '0;
        status_word[BIT_CAL]  = flags_sync[1];
        status_word[BIT_LOCK] = flags_sync[0];
    end

    always_comb begin
        rd_word = '0;
        if (dec.hit_ctrl) begin
            rd_word[HALF_W-1:0] = regs[dec.idx];
        end else if (dec.hit_status) begin
            rd_word = status_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_acc;
            if (rd_acc) begin
                rsp_rdata <= rd_word;
            end
        end
    end

    assign fields        = extract_fields(regs[BAND_IDX], regs[PWR_IDX]);
    assign phy_pwr_on    = fields.pwr_on;
    assign phy_dll_en    = fields.dll_en;
    assign phy_drive_sel = fields.drive;
    assign phy_dll_freq  = fields.band;
    assign phy_otap_en   = fields.otap_en;
    assign phy_otap_sel  = fields.otap_sel;
endmodule

// File: rtl/phyctl_regbank_chk.sv
module phyctl_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              phy_pwr_on,
    input logic              phy_dll_en,
    input logic [2:0]        phy_drive_sel,
    input logic [1:0]        phy_dll_freq,
    input logic              phy_otap_en,
    input logic [3:0]        phy_otap_sel
);
    logic acc_rd;
    logic acc_wr;
    logic [12:0] outs;

    assign acc_rd = req_valid && req_ready && !req_write;
    assign acc_wr = req_valid && req_ready && req_write;
    assign outs   = {phy_pwr_on, phy_dll_en, phy_drive_sel, phy_dll_freq,
                     phy_otap_en, phy_otap_sel};

    AST_READ_RSP: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rsp_valid); // R8

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> !rsp_valid); // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_rdata[31:16] == 16'h0000)); // R2

    AST_KEEP_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && req_addr == ADDR_W'(8'h18) && !req_wdata[16])
        |=> $stable(phy_pwr_on)); // R1

    AST_PWR_FIELD: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && req_addr == ADDR_W'(8'h18) && req_wdata[16])
        |=> (phy_pwr_on == $past(req_wdata[0]))); // R5

    AST_OTAP_FIELD: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && req_addr == ADDR_W'(8'h00) && req_wdata[27])
        |=> (phy_otap_en == $past(req_wdata[11]))); // R6

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && req_addr == ADDR_W'(8'h20)) |=> $stable(outs)); // R3

    AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && req_addr == ADDR_W'(8'h20))
        |=> ((rsp_rdata & ~32'h0000_0060) == 32'h0)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!phy_pwr_on && !phy_dll_en && phy_drive_sel == 3'd0
                 && phy_dll_freq == 2'd0 && !phy_otap_en)); // R4
endmodule

bind phyctl_regbank phyctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .phy_pwr_on    (phy_pwr_on),
    .phy_dll_en    (phy_dll_en),
    .phy_drive_sel (phy_drive_sel),
    .phy_dll_freq  (phy_dll_freq),
    .phy_otap_en   (phy_otap_en),
    .phy_otap_sel  (phy_otap_sel)
);

// File: tb/phyctl_regbank_test.sv
`timescale 1ns/1ps
module phyctl_regbank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        cal_done_in = 1'b0;
    logic        dll_lock_in = 1'b0;
    logic        phy_pwr_on, phy_dll_en, phy_otap_en;
    logic [2:0]  phy_drive_sel;
    logic [1:0]  phy_dll_freq;
    logic [3:0]  phy_otap_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [15:0] model [7];

    always #2.5 clk = ~clk;

    phyctl_regbank uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cal_done_in(cal_done_in), .dll_lock_in(dll_lock_in),
        .phy_pwr_on(phy_pwr_on), .phy_dll_en(phy_dll_en),
        .phy_drive_sel(phy_drive_sel), .phy_dll_freq(phy_dll_freq),
        .phy_otap_en(phy_otap_en), .phy_otap_sel(phy_otap_sel)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ctrl_idx(input logic [7:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (a[7:2] < 6'd7) return int'(a[7:2]);
        if (a[7:2] == 6'd8) return 8;
        return -1;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] c, input logic [31:0] w);
        return (c & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int k;
        k = ctrl_idx(a);
        if (k >= 0 && k < 7) return {16'h0, model[k]};
        if (k == 8) return {25'h0, cal_done_in, dll_lock_in, 5'h0};
        return 32'h0;
    endfunction

    function automatic logic [12:0] exp_outs();
        return {model[6][0], model[6][1], model[6][6:4], model[0][13:12],
                model[0][11], model[0][10:7]};
    endfunction

    function automatic logic [12:0] act_outs();
        return {phy_pwr_on, phy_dll_en, phy_drive_sel, phy_dll_freq,
                phy_otap_en, phy_otap_sel};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        int k;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        k = ctrl_idx(a);
        if (k >= 0 && k < 7) model[k] = merge(model[k], d);
        check(rsp_valid == 1'b0, "R8 no response after write", {31'h0, rsp_valid}, 32'h0);
        check(act_outs() == exp_outs(), "R9/R5/R6 fields after write",
              {19'h0, act_outs()}, {19'h0, exp_outs()});
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        e = exp_read(a);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R8 response valid after read", {31'h0, rsp_valid}, 32'h1);
        check(rsp_rdata == e, req, rsp_rdata, e);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 7; i++) model[i] = 16'h0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  a;
        logic [31:0] d;
        void'($urandom(32'd424242));
        do_reset();

        // R4: reset state
        @(negedge clk);
        check(act_outs() == 13'h0, "R4 outputs after reset", {19'h0, act_outs()}, 32'h0);
        check(req_ready == 1'b1, "R8 ready after reset", {31'h0, req_ready}, 32'h1);
        for (int i = 0; i < 7; i++) bus_read(8'(i * 4), "R4 control word zero after reset");

        // R1/R5: single-bit mask on power word
        bus_write(8'h18, 32'h0001_FFFF);
        check(phy_pwr_on && !phy_dll_en && phy_drive_sel == 3'd0, "R1 single-bit mask",
              {19'h0, act_outs()}, 32'h0);
        bus_write(8'h18, 32'h0000_FFFE);
        bus_read(8'h18, "R1 empty mask keeps word");
        // R5: drive code 4 = 40 ohm, dll enable
        bus_write(8'h18, 32'h0072_0042);
        check(phy_drive_sel == 3'd4 && phy_dll_en && phy_pwr_on, "R5 drive 40 ohm and dll",
              {29'h0, phy_drive_sel}, 32'h4);
        // R6: band 150 MHz, tap enable, tap select 4
        bus_write(8'h00, 32'h3F80_3A00);
        check(phy_dll_freq == 2'd3 && phy_otap_en && phy_otap_sel == 4'd4, "R6 band and tap",
              {19'h0, act_outs()}, {19'h0, exp_outs()});
        bus_write(8'h00, 32'h3000_1000);
        check(phy_dll_freq == 2'd1 && phy_otap_sel == 4'd4, "R6 band 50 MHz only",
              {30'h0, phy_dll_freq}, 32'h1);
        bus_read(8'h00, "R2 readback word 0x00");

        // R3: ignored writes
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h20, "R3 status unaffected by write");
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_read(8'h1C, "R3 gap reads zero");
        bus_write(8'h19, 32'hFFFF_FFFF);
        bus_write(8'h02, 32'hFFFF_FFFF);
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_read(8'h18, "R3 unaligned write ignored");
        bus_read(8'h00, "R3 unaligned write ignored");
        bus_read(8'h24, "R3 out of range reads zero");

        // R7: synchronizer depth with back-to-back reads
        @(negedge clk);
        cal_done_in = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h20;
        @(negedge clk);
        check(rsp_valid && rsp_rdata == 32'h0, "R7 not visible at edge k", rsp_rdata, 32'h0);
        @(negedge clk);
        check(rsp_valid && rsp_rdata == 32'h0, "R7 not visible at edge k+1", rsp_rdata, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && rsp_rdata == 32'h40, "R7 visible at edge k+2", rsp_rdata, 32'h40);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 single-cycle response", {31'h0, rsp_valid}, 32'h0);
        dll_lock_in = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(8'h20, "R7 both flags");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            if (it % 100 == 50) begin
                cal_done_in = 1'($urandom_range(0, 1));
                dll_lock_in = 1'($urandom_range(0, 1));
                repeat (3) @(negedge clk);
            end
            a = 8'($urandom_range(0, 9) * 4);
            if ($urandom_range(0, 7) == 0) a = a + 8'($urandom_range(1, 3));
            d = $urandom();
            if ($urandom_range(0, 1) == 1) bus_write(a, d);
            else bus_read(a, "R1/R2/R3/R7 random readback");
        end

        // R4: reset in the middle
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'hFFFF_FFFF);
        do_reset();
        @(negedge clk);
        check(act_outs() == 13'h0, "R4 outputs after mid-run reset", {19'h0, act_outs()}, 32'h0);
        bus_read(8'h00, "R4 word 0x00 cleared");
        bus_read(8'h18, "R4 word 0x18 cleared");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule